// File: doc/BRIEF.md
# Job Ring Occupancy Tracker

This block does the slot accounting for two circular rings that software and a job-processing engine share. Software places jobs on an input ring and takes results off an output ring. The engine takes jobs from the input ring and puts result entries on the output ring. Neither side moves an index directly. Software tells the block how many jobs it has just queued, or how many results it has just taken, by writing a count. The engine pulses one strobe for each job it takes and one strobe for each result it writes.

The block tracks the engine's input read index and output write index. It also tracks how many input slots are free and how many output entries are waiting. It raises an interrupt while results are waiting. A count that would overflow a ring is refused and reported as its own error type. A reset command clears the ring state over a short sequence whose progress can be read from status.

Register map (word addresses on the 4-bit address): 0 input size, 1 output size, 2 jobs-added (write) / free input slots (read), 3 jobs-removed (write) / waiting output entries (read), 4 input read index, 5 output write index, 6 status, 7 config (bit 0 is the interrupt mask), 8 command. Reads are combinational from `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `jring_occ_tracker`

## Requirements
- R1: Each ring size register holds only bits 9..0 of the written value, so it reads back as value mod 1024. With the input ring empty, the free-slot read at address 2 equals the input size.
- R2: Writing N to address 2 with N no greater than the free slots reduces the free slots by N. An N that exactly fills the ring is accepted and leaves 0 free.
- R3: Each engine consume strobe, when at least one job is queued, adds one free slot and advances the input read index modulo the input size. A strobe with no job queued changes nothing.
- R4: Each engine produce strobe, when the output ring is not full, adds one waiting entry and advances the output write index modulo the output size. A strobe while the output ring is full changes nothing.
- R5: Writing N to address 3 with N no greater than the waiting entries reduces the waiting entries by N.
- R6: Writing a jobs-added count larger than the free slots is refused as a whole. Counts stay unchanged, status bit 1 is set, and status bits 11..8 read 9.
- R7: Writing a jobs-removed count larger than the waiting entries is refused as a whole. Counts stay unchanged, status bit 1 is set, and status bits 11..8 read 8.
- R8: Status bit 0 becomes set while output entries are waiting and config bit 0 is clear. Writing 1 to status bit 0 clears it when that condition no longer holds. Writing 1 to status bit 1 clears the error and the error type. `irq_o` is the OR of status bits 0 and 1.
- R9: Writing 1 to command bit 0 starts a ring reset. Status bits 3..2 read 1 while the reset runs and 2 once it ends. The reset clears indices, counts and status bits 0 and 1, and afterwards the free slots equal the input size. Count writes and engine strobes have no effect while the reset runs.
- R10: After the synchronous reset input, the sizes, indices, counts, config and status all read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data |
| eng_consume | input | 1 | Engine took one job from the input ring |
| eng_produce | input | 1 | Engine wrote one entry to the output ring |
| irq_o | output | 1 | Interrupt: results waiting or error flagged |

## Verification
The hardest state to reach from the ports is an index wrapping past the end of its ring. On the input side this happens while the ring is exactly full. On the output side it happens together with a produce strobe arriving at a full ring. The stimulus reaches these states by first leaving the indices partway round the rings with the vector table. It then fills the input ring to zero free slots with one write and drives consume and produce strobes one at a time across the ring boundary. A second awkward window is the few cycles of the reset sequence. The bench issues a count write and a produce strobe inside that window, then checks at the ports that neither changed anything.

// File: rtl/jrt_pkg.sv
package jrt_pkg;

    localparam int DATA_W = 32;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        A_IN_SIZE  = 4'd0,
        A_OUT_SIZE = 4'd1,
        A_IN_ADD   = 4'd2,
        A_OUT_RMV  = 4'd3,
        A_IN_RIDX  = 4'd4,
        A_OUT_WIDX = 4'd5,
        A_STATUS   = 4'd6,
        A_CONFIG   = 4'd7,
        A_COMMAND  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        HALT_NONE = 2'd0,
        HALT_RUN  = 2'd1,
        HALT_DONE = 2'd2
    } halt_e;

    typedef enum logic [3:0] {
        ERR_NONE       = 4'd0,
        ERR_REMOVE_OVF = 4'd8,
        ERR_ADD_OVF    = 4'd9
    } err_e;

    typedef struct packed {
        err_e  etype;
        halt_e halt;
        logic  err;
        logic  int_pend;
    } status_t;

    // status word: type in 11..8, halt in 3..2, error in 1, interrupt in 0
    function automatic logic [DATA_W-1:0] pack_status(status_t s);
        return {20'd0, s.etype, 4'd0, s.halt, s.err, s.int_pend};
    endfunction

endpackage

// File: rtl/jrt_ring_side.sv
module jrt_ring_side #(
    parameter int IDX_W    = 10,
    parameter int DATA_W   = 32,
    parameter bit SW_FILLS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [IDX_W-1:0]  size,
    input  logic              eng_evt,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] sw_cnt,
    output logic [IDX_W-1:0]  occ,
    output logic [IDX_W-1:0]  free,
    output logic [IDX_W-1:0]  idx,
    output logic              sw_reject
);
    localparam int PAD_W = DATA_W - IDX_W;
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] occ_q, idx_q, occ_d, idx_d;
    logic [IDX_W-1:0] sw_limit, inc, dec, step_n;
    logic             eng_ok, sw_ok;

    assign free      = (occ_q >= size) ? '0 : size - occ_q;
    assign step_n    = sw_cnt[IDX_W-1:0];
    assign sw_reject = sw_wr && (sw_cnt > {{PAD_W{1'b0}}, sw_limit});
    assign sw_ok     = sw_wr && !sw_reject;

    generate
        if (SW_FILLS) begin : g_fill
            // software adds occupancy, engine drains it
            assign sw_limit = free;
            assign eng_ok   = eng_evt && (occ_q != '0);
            assign inc      = sw_ok  ? step_n : '0;
            assign dec      = eng_ok ? ONE    : '0;
        end else begin : g_drain
            // engine adds occupancy, software drains it
            assign sw_limit = occ_q;
            assign eng_ok   = eng_evt && (free != '0);
            assign inc      = eng_ok ? ONE    : '0;
            assign dec      = sw_ok  ? step_n : '0;
        end
    endgenerate

    assign occ_d = occ_q + inc - dec;
    assign idx_d = (idx_q >= size - ONE) ? '0 : idx_q + ONE;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            occ_q <= '0;
            idx_q <= '0;
        end else begin
            occ_q <= occ_d;
            if (eng_ok) idx_q <= idx_d;
        end
    end

    assign occ = occ_q;
    assign idx = idx_q;

    // R9
    ring_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (occ == '0 && idx == '0));

    // R3 R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!eng_evt && !clr) |=> $stable(idx));

    // R6 R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_reject && !eng_evt && !clr) |=> $stable(occ));

endmodule

// File: rtl/jrt_reset_seq.sv
module jrt_reset_seq
    import jrt_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output halt_e halt
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    halt_e            halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            halt_q <= HALT_NONE;
        end else if (start && cnt_q == '0) begin
            cnt_q  <= CNT_INIT;
            halt_q <= HALT_RUN;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_LAST;
            if (cnt_q == CNT_LAST) halt_q <= HALT_DONE;
        end
    end

    assign busy = (cnt_q != '0);
    assign halt = halt_q;

    // R9
    halt_run_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> halt == HALT_RUN);

    // R9
    halt_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> halt == HALT_DONE);

endmodule

// File: rtl/jrt_irq_status.sv
module jrt_irq_status
    import jrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       add_rej,
    input  logic       rmv_rej,
    input  logic       out_pending,
    input  logic       mask,
    input  logic       w1c_wr,
    input  logic [1:0] w1c_data,
    output logic       int_pend,
    output logic       err,
    output err_e       etype
);
    logic int_q, err_q, int_cond;
    err_e etype_q;

    assign int_cond = out_pending && !mask;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            int_q   <= 1'b0;
            err_q   <= 1'b0;
            etype_q <= ERR_NONE;
        end else begin
            if (int_cond)                    int_q <= 1'b1;
            else if (w1c_wr && w1c_data[0])  int_q <= 1'b0;

            if (add_rej) begin
                err_q   <= 1'b1;
                etype_q <= ERR_ADD_OVF;
            end else if (rmv_rej) begin
                err_q   <= 1'b1;
                etype_q <= ERR_REMOVE_OVF;
            end else if (w1c_wr && w1c_data[1]) begin
                err_q   <= 1'b0;
                etype_q <= ERR_NONE;
            end
        end
    end

    assign int_pend = int_q;
    assign err      = err_q;
    assign etype    = etype_q;

    // R8
    int_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (w1c_wr && w1c_data[0] && !int_cond && !clr) |=> !int_pend);

    // R6
    add_err_chk: assert property (@(posedge clk) disable iff (rst)
        (add_rej && !clr) |=> (err && etype == ERR_ADD_OVF));

    // R7
    rmv_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rmv_rej && !add_rej && !clr) |=> (err && etype == ERR_REMOVE_OVF));

endmodule

// File: rtl/jring_occ_tracker.sv
module jring_occ_tracker
    import jrt_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_consume,
    input  logic              eng_produce,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - IDX_W;

    logic [IDX_W-1:0] in_size_q, out_size_q;
    logic             mask_q;
    logic             busy;
    halt_e            halt;

    logic wr_in_size, wr_out_size, wr_add, wr_rmv, wr_stat, wr_cfg, wr_cmd;

    assign wr_in_size  = wr_en && (wr_addr == A_IN_SIZE);
    assign wr_out_size = wr_en && (wr_addr == A_OUT_SIZE);
    assign wr_add      = wr_en && (wr_addr == A_IN_ADD)  && !busy;
    assign wr_rmv      = wr_en && (wr_addr == A_OUT_RMV) && !busy;
    assign wr_stat     = wr_en && (wr_addr == A_STATUS);
    assign wr_cfg      = wr_en && (wr_addr == A_CONFIG);
    assign wr_cmd      = wr_en && (wr_addr == A_COMMAND) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            in_size_q  <= '0;
            out_size_q <= '0;
            mask_q     <= 1'b0;
        end else begin
            if (wr_in_size)  in_size_q  <= wr_data[IDX_W-1:0];
            if (wr_out_size) out_size_q <= wr_data[IDX_W-1:0];
            if (wr_cfg)      mask_q     <= wr_data[0];
        end
    end

    jrt_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rseq (
        .clk   (clk),
        .rst   (rst),
        .start (wr_cmd),
        .busy  (busy),
        .halt  (halt)
    );

    logic [IDX_W-1:0] in_occ, in_free, in_ridx;
    logic [IDX_W-1:0] out_occ, out_free, out_widx;
    logic             add_rej, rmv_rej;

    jrt_ring_side #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SW_FILLS(1'b1)) u_in_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (busy),
        .size      (in_size_q),
        .eng_evt   (eng_consume && !busy),
        .sw_wr     (wr_add),
        .sw_cnt    (wr_data),
        .occ       (in_occ),
        .free      (in_free),
        .idx       (in_ridx),
        .sw_reject (add_rej)
    );

    jrt_ring_side #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SW_FILLS(1'b0)) u_out_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (busy),
        .size      (out_size_q),
        .eng_evt   (eng_produce && !busy),
        .sw_wr     (wr_rmv),
        .sw_cnt    (wr_data),
        .occ       (out_occ),
        .free      (out_free),
        .idx       (out_widx),
        .sw_reject (rmv_rej)
    );

    logic int_pend, err;
    err_e etype;

    jrt_irq_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .clr         (busy),
        .add_rej     (add_rej),
        .rmv_rej     (rmv_rej),
        .out_pending (out_occ != '0),
        .mask        (mask_q),
        .w1c_wr      (wr_stat),
        .w1c_data    (wr_data[1:0]),
        .int_pend    (int_pend),
        .err         (err),
        .etype       (etype)
    );

    status_t stat;
    assign stat = '{etype: etype, halt: halt, err: err, int_pend: int_pend};

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_IN_SIZE:  rd_data = {{PAD_W{1'b0}}, in_size_q};
            A_OUT_SIZE: rd_data = {{PAD_W{1'b0}}, out_size_q};
            A_IN_ADD:   rd_data = {{PAD_W{1'b0}}, in_free};
            A_OUT_RMV:  rd_data = {{PAD_W{1'b0}}, out_occ};
            A_IN_RIDX:  rd_data = {{PAD_W{1'b0}}, in_ridx};
            A_OUT_WIDX: rd_data = {{PAD_W{1'b0}}, out_widx};
            A_STATUS:   rd_data = pack_status(stat);
            A_CONFIG:   rd_data = {{(DATA_W-1){1'b0}}, mask_q};
            default:    rd_data = '0;
        endcase
    end

    assign irq_o = int_pend | err;

    // R8
    int_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_pend) |-> $past(out_occ != '0 && !mask_q));

    // R4
    out_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (out_free == '0 && eng_produce && !wr_rmv) |=> $stable(out_occ));

endmodule

// File: tb/jring_occ_tracker_tb_top.sv
module jring_occ_tracker_tb_top;
    import jrt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    localparam logic [1:0] K_WR  = 2'd0;
    localparam logic [1:0] K_RD  = 2'd1;
    localparam logic [1:0] K_CON = 2'd2;
    localparam logic [1:0] K_PRO = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{K_WR,  4'd0, 32'h408, 32'h0,   4'd1},  // R1 size masked to 10 bits
        '{K_RD,  4'd0, 32'h0,   32'h8,   4'd1},  // R1
        '{K_WR,  4'd1, 32'h4,   32'h0,   4'd1},  // R1
        '{K_RD,  4'd2, 32'h0,   32'h8,   4'd1},  // R1 room equals size
        '{K_WR,  4'd2, 32'h3,   32'h0,   4'd2},  // R2 add 3
        '{K_RD,  4'd2, 32'h0,   32'h5,   4'd2},  // R2
        '{K_CON, 4'd0, 32'h0,   32'h0,   4'd3},  // R3 consume
        '{K_RD,  4'd2, 32'h0,   32'h6,   4'd3},  // R3
        '{K_RD,  4'd4, 32'h0,   32'h1,   4'd3},  // R3 read index
        '{K_PRO, 4'd0, 32'h0,   32'h0,   4'd4},  // R4 produce
        '{K_PRO, 4'd0, 32'h0,   32'h0,   4'd4},  // R4
        '{K_RD,  4'd3, 32'h0,   32'h2,   4'd4},  // R4 full count
        '{K_RD,  4'd5, 32'h0,   32'h2,   4'd4},  // R4 write index
        '{K_RD,  4'd6, 32'h0,   32'h1,   4'd8},  // R8 interrupt pending
        '{K_WR,  4'd3, 32'h1,   32'h0,   4'd5},  // R5 remove 1
        '{K_RD,  4'd3, 32'h0,   32'h1,   4'd5},  // R5
        '{K_WR,  4'd3, 32'h5,   32'h0,   4'd7},  // R7 over-remove
        '{K_RD,  4'd3, 32'h0,   32'h1,   4'd7},  // R7 unchanged
        '{K_RD,  4'd6, 32'h0,   32'h803, 4'd7},  // R7 type 8
        '{K_WR,  4'd6, 32'h2,   32'h0,   4'd8},  // R8 clear error
        '{K_RD,  4'd6, 32'h0,   32'h1,   4'd8},  // R8
        '{K_WR,  4'd2, 32'h7,   32'h0,   4'd6},  // R6 over-add
        '{K_RD,  4'd2, 32'h0,   32'h6,   4'd6},  // R6 unchanged
        '{K_RD,  4'd6, 32'h0,   32'h903, 4'd6},  // R6 type 9
        '{K_WR,  4'd6, 32'h2,   32'h0,   4'd6},  // R6 clear
        '{K_WR,  4'd7, 32'h1,   32'h0,   4'd8},  // R8 mask
        '{K_WR,  4'd6, 32'h1,   32'h0,   4'd8},  // R8 clear interrupt
        '{K_RD,  4'd6, 32'h0,   32'h0,   4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_consume = 1'b0;
    logic        eng_produce = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jring_occ_tracker dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .eng_consume (eng_consume),
        .eng_produce (eng_produce),
        .irq_o       (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] k, input logic [3:0] a, input logic [31:0] d,
                        input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_addr = a;
        case (k)
            K_WR:  begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
            K_CON: eng_consume = 1'b1;
            K_PRO: eng_produce = 1'b1;
            default: ;
        endcase
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        eng_consume = 1'b0;
        eng_produce = 1'b0;
        if (k == K_RD) check(tag, rd_data, e);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        step(K_RD, 4'd6, 0, 32'h0, "R10 status");
        step(K_RD, 4'd2, 0, 32'h0, "R10 room");
        step(K_RD, 4'd0, 0, 32'h0, "R10 in size");
        step(K_RD, 4'd3, 0, 32'h0, "R10 full");
        check("R10 irq", {31'd0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].kind, VECS[i].addr, VECS[i].data, VECS[i].exp,
                 $sformatf("vec%0d R%0d", i, VECS[i].req));
        end

        // R2 exact fill
        step(K_WR, 4'd2, 32'd6, 0, "R2");
        step(K_RD, 4'd2, 0, 32'd0, "R2 exact fill");
        // R3 wrap of read index
        for (int i = 0; i < 7; i++) step(K_CON, 0, 0, 0, "R3");
        step(K_RD, 4'd4, 0, 32'd0, "R3 ridx wrap");
        step(K_RD, 4'd2, 0, 32'd7, "R3 room");
        step(K_CON, 0, 0, 0, "R3");
        step(K_CON, 0, 0, 0, "R3");
        step(K_RD, 4'd4, 0, 32'd1, "R3 empty consume ignored");
        step(K_RD, 4'd2, 0, 32'd8, "R3 room full");
        // R4 wrap and full
        for (int i = 0; i < 4; i++) step(K_PRO, 0, 0, 0, "R4");
        step(K_RD, 4'd3, 0, 32'd4, "R4 full");
        step(K_RD, 4'd5, 0, 32'd1, "R4 widx wrap and full ignore");
        // R5 exact removal
        step(K_WR, 4'd3, 32'd4, 0, "R5");
        step(K_RD, 4'd3, 0, 32'd0, "R5 all removed");
        // R8 irq line
        step(K_WR, 4'd7, 32'd0, 0, "R8");
        step(K_PRO, 0, 0, 0, "R8");
        step(K_RD, 4'd6, 0, 32'h1, "R8 status");
        check("R8 irq", {31'd0, irq_o}, 32'h1);
        // R9 reset command
        step(K_WR, 4'd8, 32'd1, 0, "R9");
        step(K_RD, 4'd6, 0, 32'h4, "R9 halt in progress");
        check("R9 irq cleared", {31'd0, irq_o}, 32'h0);
        step(K_WR, 4'd2, 32'd3, 0, "R9 add during reset");
        step(K_PRO, 0, 0, 0, "R9 produce during reset");
        repeat (3) step(K_RD, 4'd0, 0, 32'd8, "R9 size kept");
        step(K_RD, 4'd6, 0, 32'h8, "R9 halt complete");
        step(K_RD, 4'd2, 0, 32'd8, "R9 room equals size");
        step(K_RD, 4'd3, 0, 32'd0, "R9 full cleared");
        step(K_RD, 4'd4, 0, 32'd0, "R9 ridx cleared");
        step(K_RD, 4'd5, 0, 32'd0, "R9 widx cleared");
        step(K_WR, 4'd2, 32'd2, 0, "R2");
        step(K_RD, 4'd2, 0, 32'd6, "R2 after ring reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule